// File: doc/BRIEF.md
# Crumb-Substitution Step Permutation

This block permutes a 256-bit state held as eight 32-bit words, `a0` through `a7`. A step applies three layers, always in the same order. The first is a bit-sliced 4-bit substitution: each "crumb" takes one bit from each of four words. The second mixes the word pairs with rotates and XORs. The third XORs a step-dependent constant pair into two of the words.

One step runs per clock. A small controller counts a fixed number of steps, eight by default, after a start request. It then raises a one-cycle completion pulse, and the final state is on the output at that time. The block is meant to sit inside a hash round, between the message-injection logic and the chaining register. That surrounding logic starts it, waits for the pulse and takes the result.

Word `k` of both the input and the output state occupies bits `32k+31:32k`.

Top module: `crumbPerm`

## Requirements
- R1: After reset, `busy` and `done` are low and `stateOut` is all zeros.
- R2: When `start` is high while `busy` is low, the next rising edge loads `stateIn` into the state. From that edge on, `stateOut` equals the loaded value and `busy` is high.
- R3: The substitution uses the table S = {13,14,0,1,5,10,7,6,11,3,9,12,15,8,2,4}, indexed by value 0 to 15. For every bit position i from 0 to 31, it is applied to two crumbs:
  - the crumb x = a0[i] + 2·a1[i] + 4·a2[i] + 8·a3[i], whose result bit j goes back to bit i of a0, a1, a2, a3 for j = 0, 1, 2, 3;
  - the crumb x = a5[i] + 2·a6[i] + 4·a7[i] + 8·a4[i], whose result bits go back, in the same way, to a5, a6, a7, a4.
- R4: After substitution, each pair (l = ak, r = ak+4) for k = 0..3 is mixed by this sequence: r ^= l; l = rotl(l,2) ^ r; r = rotl(r,14) ^ l; l = rotl(l,10) ^ r; r = rotl(r,1).
- R5: After mixing, in step s (counting from 0), a0 is XORed with C = (s+1)·0x9E3779B9 mod 2^32 and a4 is XORed with rotl(C,16) ^ 0x5A5A5A5A.
- R6: The block applies one step per clock, at each of the NUM_STEPS edges that follow the load edge. `done` is high for exactly one cycle, starting at the last of those edges. At that point `busy` is low and `stateOut` holds the state after all steps.
- R7: A `start` that arrives while `busy` is high is ignored, and the running permutation finishes with the same result as without it.
- R8: While idle, with `start` low, `stateOut` keeps its value.
- R9: A `start` raised in the same cycle as `done` is accepted, so a new permutation can begin with no idle cycle between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to load `stateIn` and run the permutation |
| stateIn | input | 256 | Initial state, word k at bits 32k+31:32k |
| busy | output | 1 | High while steps are being applied |
| done | output | 1 | One-cycle pulse when the final state is on `stateOut` |
| stateOut | output | 256 | Current state register |

## Verification
A second instance configured for a single step isolates one application of the step function. Its result is compared against an independent model for several patterns. A crumb bit routed to the wrong word, a wrong rotation amount, or layers applied in the wrong order would each produce a different word. The eight-step runs probe three timing corners:
- off-by-one step counting, which would move `done` by a cycle or give a final state off by one step;
- a restart during a run, which an unguarded controller would reload midway;
- a restart in the `done` cycle, which a controller that waits an extra idle cycle would drop.

// File: rtl/crumbPermPkg.sv
package crumbPermPkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 8;
  localparam int HALF_WORDS = NUM_WORDS / 2;
  localparam int STATE_W    = WORD_W * NUM_WORDS;
  localparam int CRUMB_W    = 4;

  // rotation amounts of the pair mixer, in order of use
  localparam int ROT_FIRST  = 2;
  localparam int ROT_SECOND = 14;
  localparam int ROT_THIRD  = 10;
  localparam int ROT_LAST   = 1;
  localparam int ROT_CONST  = WORD_W / 2;

  localparam logic [WORD_W-1:0] CONST_MUL  = 32'h9E3779B9;
  localparam logic [WORD_W-1:0] CONST_MASK = 32'h5A5A5A5A;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NUM_WORDS-1:0] stateWords_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;

  function automatic word_t rotl(input word_t v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic logic [CRUMB_W-1:0] crumbSub(input logic [CRUMB_W-1:0] x);
    case (x)
      4'd0:  return 4'd13;
      4'd1:  return 4'd14;
      4'd2:  return 4'd0;
      4'd3:  return 4'd1;
      4'd4:  return 4'd5;
      4'd5:  return 4'd10;
      4'd6:  return 4'd7;
      4'd7:  return 4'd6;
      4'd8:  return 4'd11;
      4'd9:  return 4'd3;
      4'd10: return 4'd9;
      4'd11: return 4'd12;
      4'd12: return 4'd15;
      4'd13: return 4'd8;
      4'd14: return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  function automatic word_t leftConst(input word_t idx);
    return (idx + word_t'(1)) * CONST_MUL;
  endfunction

  function automatic word_t rightConst(input word_t idx);
    return rotl(leftConst(idx), ROT_CONST) ^ CONST_MASK;
  endfunction
endpackage

// File: rtl/crumbSbox.sv
module crumbSbox
  import crumbPermPkg::*;
(
  input  logic [CRUMB_W-1:0] crumbIn,
  output logic [CRUMB_W-1:0] crumbOut
);
  always_comb crumbOut = crumbSub(crumbIn);
endmodule

// File: rtl/wordMixer.sv
module wordMixer
  import crumbPermPkg::*;
(
  input  word_t leftIn,
  input  word_t rightIn,
  output word_t leftOut,
  output word_t rightOut
);
  word_t r1, l1, r2, l2;

  always_comb begin
    r1       = rightIn ^ leftIn;
    l1       = rotl(leftIn, ROT_FIRST) ^ r1;
    r2       = rotl(r1, ROT_SECOND) ^ l1;
    l2       = rotl(l1, ROT_THIRD) ^ r2;
    leftOut  = l2;
    rightOut = rotl(r2, ROT_LAST);
  end
endmodule

// File: rtl/crumbPermCtrl.sv
module crumbPermCtrl
  import crumbPermPkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int CNT_W     = $clog2(NUM_STEPS) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] stepIdx,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_STEPS - 1);

  logic lastStep;

  always_comb begin
    lastStep      = busy && (stepIdx == LAST_IDX);
    strobes.load  = start && !busy;
    strobes.step  = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepIdx <= '0;
    end else begin
      done <= lastStep;
      if (strobes.load) begin
        busy    <= 1'b1;
        stepIdx <= '0;
      end else if (lastStep) begin
        busy    <= 1'b0;
        stepIdx <= '0;
      end else if (busy) begin
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end

  // R2: an accepted start makes the unit busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R6: done is a single-cycle pulse that ends a busy period
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy || $past(start)));
  // R6: the step counter never passes the configured count
  a_r6_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= LAST_IDX);
  // R7: a start during a run does not restart the count
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !lastStep) |=> (busy && stepIdx != '0));
endmodule

// File: rtl/crumbPermDatapath.sv
module crumbPermDatapath
  import crumbPermPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [CNT_W-1:0]   stepIdx,
  input  logic [STATE_W-1:0] stateIn,
  output logic [STATE_W-1:0] stateOut
);
  stateWords_t stateQ, subW, mixW, nextW;

  // crumb layer: two bit-sliced substitutions per bit position
  for (genvar i = 0; i < WORD_W; i++) begin : g_crumb
    logic [CRUMB_W-1:0] loIn, loOut, hiIn, hiOut;
    assign loIn = {stateQ[3][i], stateQ[2][i], stateQ[1][i], stateQ[0][i]};
    assign hiIn = {stateQ[4][i], stateQ[7][i], stateQ[6][i], stateQ[5][i]};
    crumbSbox u_lo (.crumbIn(loIn), .crumbOut(loOut));
    crumbSbox u_hi (.crumbIn(hiIn), .crumbOut(hiOut));
    assign subW[0][i] = loOut[0];
    assign subW[1][i] = loOut[1];
    assign subW[2][i] = loOut[2];
    assign subW[3][i] = loOut[3];
    assign subW[5][i] = hiOut[0];
    assign subW[6][i] = hiOut[1];
    assign subW[7][i] = hiOut[2];
    assign subW[4][i] = hiOut[3];
  end

  // word-pair mixers
  for (genvar k = 0; k < HALF_WORDS; k++) begin : g_mix
    wordMixer u_mix (
      .leftIn  (subW[k]),
      .rightIn (subW[k+HALF_WORDS]),
      .leftOut (mixW[k]),
      .rightOut(mixW[k+HALF_WORDS])
    );
  end

  // constant addition
  always_comb begin
    nextW              = mixW;
    nextW[0]          ^= leftConst(word_t'(stepIdx));
    nextW[HALF_WORDS] ^= rightConst(word_t'(stepIdx));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stateQ <= '0;
    else if (strobes.load)  stateQ <= stateWords_t'(stateIn);
    else if (strobes.step)  stateQ <= nextW;
  end

  assign stateOut = STATE_W'(stateQ);

  // R2: a load captures the input word for word
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (stateOut == $past(stateIn)));
  // R8: without load or step the state is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(stateQ));
  // R7: load and step never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load && strobes.step));
endmodule

// File: rtl/crumbPerm.sv
module crumbPerm
  import crumbPermPkg::*;
#(
  parameter int NUM_STEPS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [STATE_W-1:0] stateIn,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] stateOut
);
  localparam int CNT_W = $clog2(NUM_STEPS) + 1;

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] stepIdx;

  crumbPermCtrl #(.NUM_STEPS(NUM_STEPS), .CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .stepIdx(stepIdx),
    .busy   (busy),
    .done   (done)
  );

  crumbPermDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .stepIdx (stepIdx),
    .stateIn (stateIn),
    .stateOut(stateOut)
  );
endmodule

// File: tb/crumbPerm_tb_top.sv
module crumbPerm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0, start1 = 1'b0;
  logic [255:0] stateIn = '0, stateIn1 = '0;
  logic         busy, done, busy1, done1;
  logic [255:0] stateOut, stateOut1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crumbPerm #(.NUM_STEPS(STEPS)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .stateIn(stateIn),
    .busy(busy), .done(done), .stateOut(stateOut));

  crumbPerm #(.NUM_STEPS(1)) oneStep_i (
    .clk(clk), .rstN(rstN), .start(start1), .stateIn(stateIn1),
    .busy(busy1), .done(done1), .stateOut(stateOut1));

  // ---------------- reference model ----------------
  localparam bit [3:0] SB [16] = '{4'd13,4'd14,4'd0,4'd1,4'd5,4'd10,4'd7,4'd6,
                                   4'd11,4'd3,4'd9,4'd12,4'd15,4'd8,4'd2,4'd4};

  function automatic bit [31:0] mRot(bit [31:0] v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic bit [31:0] mWord(bit [255:0] s, int k);
    return s[32*k +: 32];
  endfunction

  function automatic bit [255:0] mStep(bit [255:0] s, int idx);
    bit [31:0] a [8];
    bit [31:0] c;
    bit [255:0] r;
    for (int k = 0; k < 8; k++) a[k] = mWord(s, k);
    for (int i = 0; i < 32; i++) begin
      bit [3:0] x, y;
      x = {a[3][i], a[2][i], a[1][i], a[0][i]};
      y = SB[x];
      a[0][i] = y[0]; a[1][i] = y[1]; a[2][i] = y[2]; a[3][i] = y[3];
      x = {a[4][i], a[7][i], a[6][i], a[5][i]};
      y = SB[x];
      a[5][i] = y[0]; a[6][i] = y[1]; a[7][i] = y[2]; a[4][i] = y[3];
    end
    for (int k = 0; k < 4; k++) begin
      bit [31:0] l, rr;
      l = a[k]; rr = a[k+4];
      rr ^= l;
      l = mRot(l, 2) ^ rr;
      rr = mRot(rr, 14) ^ l;
      l = mRot(l, 10) ^ rr;
      rr = mRot(rr, 1);
      a[k] = l; a[k+4] = rr;
    end
    c = 32'(idx + 1) * 32'h9E3779B9;
    a[0] ^= c;
    a[4] ^= mRot(c, 16) ^ 32'h5A5A5A5A;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = a[k];
    return r;
  endfunction

  function automatic bit [255:0] mRun(bit [255:0] s);
    bit [255:0] t = s;
    for (int i = 0; i < STEPS; i++) t = mStep(t, i);
    return t;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [255:0] v);
    @(negedge clk);
    start = 1'b1; stateIn = v;
    @(negedge clk);
    start = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    check(busy == 1'b0, "R1 busy", 256'(busy), 256'(0));
    check(done == 1'b0, "R1 done", 256'(done), 256'(0));
    check(stateOut == '0, "R1 stateOut", stateOut, '0);
  endtask

  task automatic tOneStep(input logic [255:0] v);
    logic [255:0] exp;
    exp = mStep(v, 0);
    @(negedge clk);
    start1 = 1'b1; stateIn1 = v;
    @(negedge clk);
    start1 = 1'b0;
    check(stateOut1 == v, "R2 single-step load", stateOut1, v);
    @(negedge clk);
    check(done1 && stateOut1 == exp, "R3 R4 R5 single step result", stateOut1, exp);
  endtask

  task automatic tFullRun(input logic [255:0] v);
    logic [255:0] exp;
    bit earlyDone = 1'b0;
    exp = mRun(v);
    launch(v);
    check(stateOut == v && busy, "R2 load and busy", stateOut, v);
    for (int i = 0; i < STEPS - 1; i++) begin
      @(negedge clk);
      if (done || !busy) earlyDone = 1'b1;
    end
    check(!earlyDone, "R6 no early done", 256'(earlyDone), 256'(0));
    @(negedge clk);
    check(done && !busy, "R6 done timing", {done, busy}, 256'b10);
    check(stateOut == exp, "R6 final state", stateOut, exp);
    @(negedge clk);
    check(!done, "R6 done one cycle", 256'(done), 256'(0));
  endtask

  task automatic tIgnoreStart(input logic [255:0] v, input logic [255:0] other);
    logic [255:0] exp;
    exp = mRun(v);
    launch(v);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; stateIn = other;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < STEPS - 3; i++) @(negedge clk);
    check(done && stateOut == exp, "R7 start ignored while busy", stateOut, exp);
  endtask

  task automatic tHold();
    logic [255:0] held;
    held = stateOut;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(stateOut == held && !busy, "R8 idle hold", stateOut, held);
  endtask

  task automatic tBackToBack(input logic [255:0] a, input logic [255:0] b);
    logic [255:0] exp;
    exp = mRun(b);
    launch(a);
    for (int i = 0; i < STEPS - 1; i++) @(negedge clk);
    @(negedge clk);
    start = 1'b1; stateIn = b;
    check(done == 1'b1, "R9 done before restart", 256'(done), 256'(1));
    @(negedge clk);
    start = 1'b0;
    check(stateOut == b && busy, "R9 restart accepted in done cycle", stateOut, b);
    for (int i = 0; i < STEPS; i++) @(negedge clk);
    check(done && stateOut == exp, "R9 second run result", stateOut, exp);
  endtask

  // ---------------- main ----------------
  initial begin
    #(CLK_PERIOD * 3);
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tOneStep('0);
    tOneStep({8{32'hFFFF_FFFF}});
    tOneStep({32'h0000_0080, 32'h0001_0000, 32'h1234_5678, 32'h8000_0001,
              32'hDEAD_BEEF, 32'h0F0F_0F0F, 32'h0000_0002, 32'hCAFE_F00D});
    tFullRun('0);
    tFullRun({32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0});
    tFullRun({4{64'hAAAA_5555_3333_CCCC}});
    tIgnoreStart({8{32'h0123_4567}}, {8{32'hFEDC_BA98}});
    tHold();
    tBackToBack({8{32'h1111_1111}}, {32'h8000_0000, {7{32'h0}}});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule